// File: doc/BRIEF.md
# Calibration Register Parity Monitor

This block holds a bank of calibration words and guards it with parity. After reset it fetches every word from a nonvolatile store over a request/valid read port. It then checks all the words once. Only when that check is clean does it declare the measurement output valid. From then on it keeps walking the bank, one word per clock, in an endless scan.

A parity error starts a full reload from the store, followed by a fresh check. If that check is clean, the block goes back to normal scanning and the fault flag stays low. If the error is still present, the block enters a failure state that only reset clears. In that state the reported code is held at zero, below the valid window of 102 to 1945 counts on the 11-bit scale. A separate interconnection-fault input also pulls the reported code to zero while it is high.

The surrounding logic reads the calibration data through a word-select port. An upset input models a bit flip inside the bank, so that a corrupted register can be reproduced.

Top module: `cal_parity_guard`

## Requirements
- R1: While reset is held, and right after it, `ready` and `fail` are 0 and `out_code` is 0. After reset the block reads words 0 up to WORDS-1 from the store in ascending address order, with at most one request outstanding; `nv_req` is a one-cycle strobe qualified by `nv_addr`.
- R2: With a clean store, `ready` rises no later than WORDS*(L+1)+WORDS+4 cycles after reset release, where L is the number of cycles from a request to its `nv_valid`.
- R3: While `ready` is 1 and `link_fault` is 0, `out_code` equals the `meas_code` sampled one clock earlier. This includes the window edges 102 and 1945.
- R4: Each stored word is WW=DW+1 bits wide: data in bits DW-1:0 and an even-parity bit in bit DW, so a good word has an even count of ones. `cal_rd_data` combinationally returns the data field of the word at `cal_rd_addr`.
- R5: A single-bit upset of one word while running is found within WORDS cycles. `ready` then drops and `out_code` reads 0 during the reload. The bank is reloaded and checked, `ready` returns, `fail` stays 0, and the word holds its stored value again.
- R6: If the check after a reload finds a parity error, `fail` goes to 1 and `ready` to 0. `fail` then stays at 1 and `out_code` at 0 until reset, whatever `meas_code` does.
- R7: If the store itself returns a word with bad parity at power-up, the block makes exactly one reload (2*WORDS requests in total) and then sets `fail`.
- R8: `link_fault` high forces `out_code` to 0 one cycle later without changing `ready`. Once it drops, the code follows `meas_code` again.
- R9: `nv_req` is never asserted while `ready` or `fail` is 1.
- R10: Reset clears a latched failure, and a clean store then brings `ready` back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nv_req | output | 1 | Read strobe to the nonvolatile store |
| nv_addr | output | AW | Word address of the read |
| nv_valid | input | 1 | Read data is present |
| nv_data | input | WW | Stored word, parity in the top bit |
| upset_en | input | 1 | Apply a bit-flip to one bank word |
| upset_addr | input | AW | Word hit by the flip |
| upset_mask | input | WW | Bits inverted by the flip |
| cal_rd_addr | input | AW | Calibration word select |
| cal_rd_data | output | DW | Data field of the selected word |
| meas_code | input | CW | Measurement code from the sensing path |
| link_fault | input | 1 | Interconnection fault indication |
| out_code | output | CW | Reported code, 0 when not valid |
| ready | output | 1 | Calibration loaded and clean |
| fail | output | 1 | Latched failure |

## Verification
The assertions cover the properties that hold on every clock:
- the latched failure is sticky and keeps the code at zero;
- an interconnection fault zeroes the next code;
- `ready` and `fail` are never both high;
- no store read is issued while the block is ready or failed;
- failure is entered only from a non-ready state.

The directed scenarios show the rest:
- the order of the reads after reset, and the bound on the ready time;
- detection and repair of a single upset;
- escalation to failure when the store itself holds bad parity, both at run time and at power-up;
- clearing of the failure by reset.

// File: rtl/cal_parity_guard.sv
module cal_parity_guard #(
  parameter int WORDS = 8,
  parameter int DW = 16,
  parameter int CW = 11,
  parameter int FAIL_CODE = 0,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int WW = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          nv_req,
  output logic [AW-1:0] nv_addr,
  input  logic          nv_valid,
  input  logic [WW-1:0] nv_data,
  input  logic          upset_en,
  input  logic [AW-1:0] upset_addr,
  input  logic [WW-1:0] upset_mask,
  input  logic [AW-1:0] cal_rd_addr,
  output logic [DW-1:0] cal_rd_data,
  input  logic [CW-1:0] meas_code,
  input  logic          link_fault,
  output logic [CW-1:0] out_code,
  output logic          ready,
  output logic          fail
);

  typedef enum logic [1:0] {S_LOAD, S_CHECK, S_RUN, S_FAIL} st_t;

  st_t           st;
  logic [WW-1:0] bank [WORDS];
  logic [AW-1:0] idx;
  logic          waiting;
  logic          reloaded;

  wire last = (idx == AW'(WORDS - 1));
  wire perr = ^bank[idx];
  wire take = (st == S_LOAD) && waiting && nv_valid;

  assign nv_req      = (st == S_LOAD) && !waiting;
  assign nv_addr     = idx;
  assign ready       = (st == S_RUN);
  assign fail        = (st == S_FAIL);
  assign cal_rd_data = bank[cal_rd_addr][DW-1:0];

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (take && idx == AW'(i))
        bank[i] <= nv_data;
      else if (upset_en && upset_addr == AW'(i))
        bank[i] <= bank[i] ^ upset_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_LOAD;
      idx      <= '0;
      waiting  <= 1'b0;
      reloaded <= 1'b0;
    end else begin
      case (st)
        S_LOAD: begin
          if (!waiting) begin
            waiting <= 1'b1;
          end else if (nv_valid) begin
            waiting <= 1'b0;
            if (last) begin
              idx <= '0;
              st  <= S_CHECK;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_CHECK: begin
          if (perr) begin
            idx <= '0;
            if (reloaded) begin
              st <= S_FAIL;
            end else begin
              reloaded <= 1'b1;
              st       <= S_LOAD;
            end
          end else if (last) begin
            idx      <= '0;
            reloaded <= 1'b0;
            st       <= S_RUN;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_RUN: begin
          if (perr) begin
            idx      <= '0;
            reloaded <= 1'b1;
            st       <= S_LOAD;
          end else begin
            idx <= last ? '0 : idx + 1'b1;
          end
        end
        default: st <= S_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_code <= CW'(FAIL_CODE);
    else
      out_code <= (st == S_RUN && !link_fault) ? meas_code : CW'(FAIL_CODE);
  end

endmodule

// File: rtl/cal_parity_guard_chk.sv
module cal_parity_guard_chk #(
  parameter int CW = 11,
  parameter int FAIL_CODE = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nv_req,
  input logic          link_fault,
  input logic [CW-1:0] out_code,
  input logic          ready,
  input logic          fail
);

  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);

  // R6
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> out_code == CW'(FAIL_CODE));

  // R8
  link_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_fault |=> out_code == CW'(FAIL_CODE));

  // R6
  excl_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && fail));

  // R9
  quiet_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req |-> !ready && !fail);

  // R6
  fail_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> !$past(ready));

endmodule

bind cal_parity_guard cal_parity_guard_chk #(.CW(CW), .FAIL_CODE(FAIL_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .nv_req(nv_req), .link_fault(link_fault),
  .out_code(out_code), .ready(ready), .fail(fail)
);

// File: tb/tb_cal_parity_guard.sv
module tb_cal_parity_guard;
  localparam int WORDS = 8;
  localparam int DW = 16;
  localparam int CW = 11;
  localparam int AW = 3;
  localparam int WW = DW + 1;
  localparam int LAT = 3;
  localparam int L = LAT + 1;
  localparam int BOUND = WORDS * (L + 1) + WORDS + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nv_req, nv_valid;
  logic [AW-1:0] nv_addr, upset_addr, cal_rd_addr;
  logic [WW-1:0] nv_data, upset_mask;
  logic upset_en, link_fault;
  logic [DW-1:0] cal_rd_data;
  logic [CW-1:0] meas_code, out_code;
  logic ready, fail;

  int checks = 0;
  int errors = 0;
  logic bad_en = 1'b0;
  logic [AW-1:0] bad_addr = '0;

  always #4 clk = ~clk;

  cal_parity_guard #(.WORDS(WORDS), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .nv_req(nv_req), .nv_addr(nv_addr),
    .nv_valid(nv_valid), .nv_data(nv_data), .upset_en(upset_en),
    .upset_addr(upset_addr), .upset_mask(upset_mask),
    .cal_rd_addr(cal_rd_addr), .cal_rd_data(cal_rd_data),
    .meas_code(meas_code), .link_fault(link_fault), .out_code(out_code),
    .ready(ready), .fail(fail));

  function automatic logic [DW-1:0] wdata(input int i);
    return DW'(16'h1357 ^ (i * 16'h0F0F) ^ (i << 11));
  endfunction

  logic pend = 1'b0;
  int cnt = 0;
  logic [AW-1:0] pa = '0;
  always @(posedge clk) begin
    nv_valid <= 1'b0;
    if (nv_req) begin
      pend <= 1'b1; cnt <= LAT; pa <= nv_addr;
    end else if (pend) begin
      if (cnt == 1) begin
        pend <= 1'b0;
        nv_valid <= 1'b1;
        nv_data <= {(^wdata(int'(pa))) ^ (bad_en && pa == bad_addr), wdata(int'(pa))};
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 4 * BOUND) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready == 0 && fail == 0, "R1 reset flags", {ready, fail}, 0);
    chk(out_code == 0, "R1 reset code", out_code, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_boot;
    int nexp = 0, n = 0;
    logic order_ok = 1'b1;
    t_reset();
    while (!ready && n < 4 * BOUND) begin
      if (nv_req) begin
        if (nv_addr != AW'(nexp)) order_ok = 1'b0;
        nexp++;
      end
      @(negedge clk); n++;
    end
    chk(order_ok && nexp == WORDS, "R1 read order", nexp, WORDS);
    chk(ready && n <= BOUND, "R2 ready time", n, BOUND);
    for (int i = 0; i < WORDS; i++) begin
      cal_rd_addr = AW'(i); #1;
      chk(cal_rd_data == wdata(i), "R4 word data", cal_rd_data, wdata(i));
    end
  endtask

  task automatic t_pass;
    int vals[3] = '{102, 1945, 1024};
    foreach (vals[k]) begin
      @(negedge clk); meas_code = CW'(vals[k]);
      @(negedge clk);
      chk(out_code == CW'(vals[k]), "R3 passthrough", out_code, vals[k]);
    end
  endtask

  task automatic t_quiet;
    int seen = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); if (nv_req) seen++; end
    chk(seen == 0 && ready, "R9 no reads while ready", seen, 0);
  endtask

  task automatic t_link;
    @(negedge clk); meas_code = 11'd700; link_fault = 1'b1;
    @(negedge clk);
    chk(out_code == 0, "R8 link fault code", out_code, 0);
    chk(ready == 1, "R8 ready kept", ready, 1);
    link_fault = 1'b0;
    @(negedge clk);
    chk(out_code == 11'd700, "R8 recovered", out_code, 700);
  endtask

  task automatic t_upset;
    int n = 0, zero_bad = 0;
    @(negedge clk); upset_en = 1'b1; upset_addr = 3'd5; upset_mask = WW'(8);
    @(negedge clk); upset_en = 1'b0;
    while (ready && n < WORDS + 2) begin @(negedge clk); n++; end
    chk(!ready, "R5 upset detected", n, WORDS);
    @(negedge clk);
    n = 0;
    while (!ready && n < 4 * BOUND) begin
      if (out_code != 0) zero_bad++;
      @(negedge clk); n++;
    end
    chk(zero_bad == 0, "R5 code zero in reload", zero_bad, 0);
    chk(ready && fail == 0, "R5 recovered without fail", {ready, fail}, 2);
    cal_rd_addr = 3'd5; #1;
    chk(cal_rd_data == wdata(5), "R5 word restored", cal_rd_data, wdata(5));
  endtask

  task automatic t_persist;
    int n = 0, bad = 0;
    bad_en = 1'b1; bad_addr = 3'd2;
    @(negedge clk); upset_en = 1'b1; upset_addr = 3'd2; upset_mask = WW'(1);
    @(negedge clk); upset_en = 1'b0;
    while (!fail && n < 4 * BOUND) begin @(negedge clk); n++; end
    chk(fail && !ready, "R6 fail latched", {fail, ready}, 2);
    for (int c = 0; c < 30; c++) begin
      meas_code = CW'(500 + c);
      @(negedge clk);
      if (!fail || out_code != 0 || nv_req) bad++;
    end
    chk(bad == 0, "R6 sticky and zero", bad, 0);
  endtask

  task automatic t_clear;
    int n;
    bad_en = 1'b0;
    t_reset();
    wait_ready(n);
    chk(ready && !fail, "R10 reset clears fail", {ready, fail}, 2);
  endtask

  task automatic t_boot_bad;
    int reqs = 0, n = 0;
    bad_en = 1'b1; bad_addr = 3'd7;
    t_reset();
    while (!fail && n < 8 * BOUND) begin
      if (nv_req) reqs++;
      @(negedge clk); n++;
    end
    chk(fail == 1, "R7 boot fail", fail, 1);
    chk(reqs == 2 * WORDS, "R7 one reload", reqs, 2 * WORDS);
    bad_en = 1'b0;
  endtask

  initial begin
    upset_en = 0; upset_addr = '0; upset_mask = '0; cal_rd_addr = '0;
    meas_code = '0; link_fault = 0;
    t_boot();
    t_pass();
    t_quiet();
    t_link();
    t_upset();
    t_pass();
    t_persist();
    t_clear();
    t_boot_bad();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule